// File: doc/BRIEF.md
# Vector Floating-Point Power-of-Two Scaling Unit

This block multiplies every floating-point element of a 128-bit SIMD operand by a power of two. The exponent comes from the element in the same position of a second 128-bit operand, read as a signed two's-complement integer of the same width. A mode input selects the element width. With `dbl_i` low, the operand holds four binary32 elements and the scale elements are 32 bits wide. With `dbl_i` high, it holds two binary64 elements and the scale elements are 64 bits wide. Element n occupies bits `[n*W +: W]`, where W is the element width. For finite inputs each element returns `x * 2^y`, rounded once with round-to-nearest-even. The unit raises a per-element overflow flag and a per-element underflow flag.

Each element datapath works as follows. It sorts the input into one of zero, subnormal, normal, infinity or NaN. It normalises subnormals, saturates the scale integer to a small window so that the exponent sum cannot wrap, and adds the two. The sum then goes to one of four paths: the normal path, the overflow path, the denormalising round path or the flush-to-zero path. Both element widths are computed at all times, and the mode bit picks which result is registered.

A two-state controller sequences the output. In `ST_IDLE` no new result is presented. In `ST_SHOW` the result register holds the result of the operands accepted on the previous edge. The transition `ST_IDLE -> ST_SHOW` happens on an edge where `vld_i` is high. The transition `ST_SHOW -> ST_IDLE` happens on an edge where `vld_i` is low. The self-loops `ST_SHOW -> ST_SHOW` and `ST_IDLE -> ST_IDLE` follow from `vld_i` staying high or staying low. The result register loads only while `vld_i` is high.

Top module: `vfs_top`

## Requirements
- R1: With `dbl_i` = 0, each 32-bit element of `src_a_i` is a binary32 value and is scaled by the signed 32-bit element at the same position of `src_k_i`. For example, 0x3f800000 scaled by -1 gives 0x3f000000, 0x3f900000 by 2 gives 0x40900000, 0x3fc00000 by 3 gives 0x41400000 and 0x3fe00000 by 4 gives 0x41e00000.
- R2: With `dbl_i` = 1, each 64-bit element is a binary64 value (1 sign bit, 11 exponent bits, 52 fraction bits) and is scaled by the signed 64-bit element at the same position of `src_k_i`.
- R3: A finite nonzero input whose scaled biased exponent reaches the all-ones value yields an infinity with the input's sign (all-ones exponent, zero fraction). It also sets that element's bit in `ovf_o`.
- R4: A finite result below the normal range is denormalised and rounded once, to nearest with ties to even. A result that rounds up to the smallest normal number is encoded as a normal.
- R5: A nonzero finite input whose rounded result is zero yields zero with the input's sign and sets that element's bit in `unf_o`. No element ever has both its `ovf_o` bit and its `unf_o` bit set.
- R6: Zero, infinity and quiet NaN inputs (a quiet NaN has fraction MSB = 1) are returned bit for bit, whatever the scale value, with both flags clear.
- R7: A signalling NaN input (all-ones exponent, fraction MSB = 0, fraction nonzero) is returned with its fraction MSB set and all other bits unchanged.
- R8: A subnormal input is normalised before scaling, so its full precision is kept. For example, 0x00000001 scaled by 149 gives 0x3f800000.
- R9: Scale values of any magnitude, including the most negative and most positive integers of the element width, give the same result as exact arithmetic.
- R10: `vld_o` equals `vld_i` delayed by exactly one clock. Results and flags appear one clock after the operands are presented with `vld_i` high.
- R11: While `vld_i` is low, `res_o`, `ovf_o` and `unf_o` keep their previous values, whatever happens on the operand and mode inputs.
- R12: After reset, `vld_o`, `res_o`, `ovf_o` and `unf_o` are all zero.
- R13: With `dbl_i` = 1, element flags are reported in `ovf_o[1:0]` and `unf_o[1:0]`, and bits 3:2 of both flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operands and mode are valid this cycle |
| dbl_i | input | 1 | 0: four binary32 elements, 1: two binary64 elements |
| src_a_i | input | 128 | Floating-point data operand |
| src_k_i | input | 128 | Signed integer scale operand |
| vld_o | output | 1 | Result registered on the last edge is fresh |
| res_o | output | 128 | Scaled result |
| ovf_o | output | 4 | Per-element overflow flags |
| unf_o | output | 4 | Per-element underflow (flush to zero) flags |

## Verification
On every cycle, the assertions check the output timing and the flag encodings. They check the one-clock valid latency, that the result is held while `vld_i` is low, and that overflow and underflow are never flagged together. They also check that a raised overflow flag comes with an infinity, that a raised underflow flag comes with a zero of the matching width, and that the upper flag bits stay clear in binary64 mode. The numeric content is shown only by the bench scenarios, which compare against an exact integer model: correct rounding of subnormal results, the tie cases at the flush boundary, normalisation of subnormal inputs, NaN quieting and saturation of extreme scale integers.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    // binary32 field widths
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    // binary64 field widths
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;

    // output sequencing states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } vfs_state_e;

    // operand classes inside one element
    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_SUB  = 3'd1,
        FC_NORM = 3'd2,
        FC_INF  = 3'd3,
        FC_NAN  = 3'd4
    } fp_class_e;

endpackage

// File: rtl/vfs_lane.sv
module vfs_lane
    import vfs_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] k_i,
    output logic [EXP_W+MAN_W:0] y_o,
    output logic                 ovf_o,
    output logic                 unf_o
);

    localparam int W    = EXP_W + MAN_W + 1;
    localparam int SW   = EXP_W + 4;            // exponent arithmetic width
    localparam int LZW  = $clog2(MAN_W + 1) + 1;
    localparam int SIGW = MAN_W + 1;            // significand with hidden bit
    localparam int RW   = MAN_W + 2;            // rounding workspace
    localparam int LIM  = 2 ** (EXP_W + 1);     // scale saturation bound
    localparam logic signed [W-1:0]  K_HI  = W'(LIM);
    localparam logic signed [W-1:0]  K_LO  = -K_HI;
    localparam logic signed [SW-1:0] E_TOP = SW'((2 ** EXP_W) - 1);
    localparam logic signed [SW-1:0] E_ONE = SW'(1);
    localparam logic signed [SW-1:0] SH_MAX = SW'(MAN_W + 2);

    logic                    sgn;
    logic [EXP_W-1:0]        fexp;
    logic [MAN_W-1:0]        frac;
    fp_class_e               cls;
    logic [LZW-1:0]          lz;
    logic                    lz_hit;
    logic [SIGW-1:0]         sig;
    logic signed [SW-1:0]    eb;
    logic signed [SW-1:0]    ksat;
    logic signed [SW-1:0]    esum;
    logic signed [SW-1:0]    shamt;
    logic [SW-1:0]           shv;
    logic [RW-1:0]           wide;
    logic [RW-1:0]           quo;
    logic [RW-1:0]           rem;
    logic [RW-1:0]           half;
    logic [RW-1:0]           mask;
    logic                    rnd_up;
    logic [EXP_W+MAN_W-1:0]  mag_sub;

    assign {sgn, fexp, frac} = a_i;

    // operand classification
    always_comb begin
        if (fexp == '1) begin
            cls = (frac == '0) ? FC_INF : FC_NAN;
        end else if (fexp == '0) begin
            cls = (frac == '0) ? FC_ZERO : FC_SUB;
        end else begin
            cls = FC_NORM;
        end
    end

    // leading zeros of the fraction, for subnormal normalisation
    always_comb begin
        lz     = '0;
        lz_hit = 1'b0;
        for (int b = MAN_W - 1; b >= 0; b--) begin
            if (!lz_hit) begin
                if (frac[b]) begin
                    lz_hit = 1'b1;
                end else begin
                    lz = lz + 1'b1;
                end
            end
        end
    end

    // significand with leading one at bit MAN_W, and its biased exponent
    always_comb begin
        if (cls == FC_SUB) begin
            sig = SIGW'({1'b0, frac} << (lz + 1'b1));
            eb  = -$signed(SW'(lz));
        end else begin
            sig = {1'b1, frac};
            eb  = $signed(SW'(fexp));
        end
    end

    // saturate the full-width scale integer into the exponent window
    always_comb begin
        if ($signed(k_i) > K_HI) begin
            ksat = $signed(SW'(LIM));
        end else if ($signed(k_i) < K_LO) begin
            ksat = -$signed(SW'(LIM));
        end else begin
            ksat = $signed(k_i[SW-1:0]);
        end
    end

    assign esum  = eb + ksat;
    assign shamt = E_ONE - esum;
    assign shv   = shamt;

    // right shift into the subnormal range with nearest-even rounding
    always_comb begin
        wide    = {1'b0, sig};
        mask    = (RW'(1) << shv) - RW'(1);
        quo     = wide >> shv;
        rem     = wide & mask;
        half    = RW'(1) << (shv - SW'(1));
        rnd_up  = (rem > half) || ((rem == half) && quo[0]);
        mag_sub = (EXP_W + MAN_W)'(quo) + (EXP_W + MAN_W)'(rnd_up);
    end

    // result selection
    always_comb begin
        y_o   = a_i;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        unique case (cls)
            FC_ZERO, FC_INF: begin
                y_o = a_i;
            end
            FC_NAN: begin
                y_o = a_i | (W'(1) << (MAN_W - 1));
            end
            FC_SUB, FC_NORM: begin
                if (esum >= E_TOP) begin
                    y_o   = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
                    ovf_o = 1'b1;
                end else if (esum >= E_ONE) begin
                    y_o = {sgn, esum[EXP_W-1:0], sig[MAN_W-1:0]};
                end else if (shamt >= SH_MAX) begin
                    y_o   = {sgn, {(W-1){1'b0}}};
                    unf_o = 1'b1;
                end else begin
                    y_o   = {sgn, mag_sub};
                    unf_o = (mag_sub == '0);
                end
            end
            default: begin
                y_o = a_i;
            end
        endcase
    end

endmodule

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
    import vfs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    output logic load_o,
    output logic vld_o
);

    vfs_state_e st_q;
    vfs_state_e st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (vld_i)  st_d = ST_SHOW;
            ST_SHOW: if (!vld_i) st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    always_comb begin
        load_o = vld_i;
        vld_o  = (st_q == ST_SHOW);
    end

endmodule

// File: rtl/vfs_top.sv
module vfs_top
    import vfs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  vld_i,
    input  logic                  dbl_i,
    input  logic [VEC_W-1:0]      src_a_i,
    input  logic [VEC_W-1:0]      src_k_i,
    output logic                  vld_o,
    output logic [VEC_W-1:0]      res_o,
    output logic [VEC_W/32-1:0]   ovf_o,
    output logic [VEC_W/32-1:0]   unf_o
);

    localparam int SP_W = 1 + SP_EXP + SP_MAN;
    localparam int DP_W = 1 + DP_EXP + DP_MAN;
    localparam int NSP  = VEC_W / SP_W;
    localparam int NDP  = VEC_W / DP_W;

    logic [VEC_W-1:0] sp_res;
    logic [VEC_W-1:0] dp_res;
    logic [NSP-1:0]   sp_ovf;
    logic [NSP-1:0]   sp_unf;
    logic [NDP-1:0]   dp_ovf;
    logic [NDP-1:0]   dp_unf;
    logic [VEC_W-1:0] res_d;
    logic [NSP-1:0]   ovf_d;
    logic [NSP-1:0]   unf_d;
    logic             load;

    // binary32 element datapaths
    for (genvar g = 0; g < NSP; g++) begin : g_sp
        vfs_lane #(
            .EXP_W (SP_EXP),
            .MAN_W (SP_MAN)
        ) u_lane (
            .a_i   (src_a_i[g*SP_W +: SP_W]),
            .k_i   (src_k_i[g*SP_W +: SP_W]),
            .y_o   (sp_res[g*SP_W +: SP_W]),
            .ovf_o (sp_ovf[g]),
            .unf_o (sp_unf[g])
        );
    end

    // binary64 element datapaths
    for (genvar g = 0; g < NDP; g++) begin : g_dp
        vfs_lane #(
            .EXP_W (DP_EXP),
            .MAN_W (DP_MAN)
        ) u_lane (
            .a_i   (src_a_i[g*DP_W +: DP_W]),
            .k_i   (src_k_i[g*DP_W +: DP_W]),
            .y_o   (dp_res[g*DP_W +: DP_W]),
            .ovf_o (dp_ovf[g]),
            .unf_o (dp_unf[g])
        );
    end

    // width-mode selection
    always_comb begin
        if (dbl_i) begin
            res_d = dp_res;
            ovf_d = NSP'(dp_ovf);
            unf_d = NSP'(dp_unf);
        end else begin
            res_d = sp_res;
            ovf_d = sp_ovf;
            unf_d = sp_unf;
        end
    end

    vfs_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (vld_i),
        .load_o (load),
        .vld_o  (vld_o)
    );

    // result register, loaded only on valid cycles
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_o <= '0;
            ovf_o <= '0;
            unf_o <= '0;
        end else if (load) begin
            res_o <= res_d;
            ovf_o <= ovf_d;
            unf_o <= unf_d;
        end
    end

endmodule

// File: rtl/vfs_checks.sv
module vfs_checks #(
    parameter int VEC_W = 128
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                vld_i,
    input logic                dbl_i,
    input logic                vld_o,
    input logic [VEC_W-1:0]    res_o,
    input logic [VEC_W/32-1:0] ovf_o,
    input logic [VEC_W/32-1:0] unf_o
);

    localparam int NSP = VEC_W / 32;
    localparam int NDP = VEC_W / 64;

    // mode of the result currently on the outputs
    logic dbl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dbl_q <= 1'b0;
        end else if (vld_i) begin
            dbl_q <= dbl_i;
        end
    end

    a_r10_valid_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_i |=> vld_o);

    a_r10_valid_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |=> !vld_o);

    a_r11_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |=> ($stable(res_o) && $stable(ovf_o) && $stable(unf_o)));

    a_r5_flags_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o & unf_o) == '0);

    a_r13_upper_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && dbl_i) |=> (ovf_o[NSP-1:NDP] == '0 && unf_o[NSP-1:NDP] == '0));

    for (genvar i = 0; i < NSP; i++) begin : g_sp_chk
        a_r3_ovf_gives_inf_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!dbl_q && ovf_o[i]) |-> (res_o[32*i +: 31] == {8'hff, 23'h0}));
        a_r5_unf_gives_zero_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!dbl_q && unf_o[i]) |-> (res_o[32*i +: 31] == 31'h0));
    end

    for (genvar j = 0; j < NDP; j++) begin : g_dp_chk
        a_r3_ovf_gives_inf_dp: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dbl_q && ovf_o[j]) |-> (res_o[64*j +: 63] == {11'h7ff, 52'h0}));
        a_r5_unf_gives_zero_dp: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dbl_q && unf_o[j]) |-> (res_o[64*j +: 63] == 63'h0));
    end

endmodule

bind vfs_top vfs_checks #(.VEC_W(VEC_W)) u_checks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_i),
    .dbl_i  (dbl_i),
    .vld_o  (vld_o),
    .res_o  (res_o),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
);

// File: tb/tb_vfs_top.sv
`timescale 1ns/1ps
module tb_vfs_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         vld_i;
    logic         dbl_i;
    logic [127:0] src_a;
    logic [127:0] src_k;
    logic         vld_o;
    logic [127:0] res_o;
    logic [3:0]   ovf_o;
    logic [3:0]   unf_o;

    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    logic         e_vld;
    logic [127:0] e_res;
    logic [3:0]   e_ovf;
    logic [3:0]   e_unf;
    string        e_tag;

    always #2.5 clk = ~clk;

    vfs_top dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .vld_i   (vld_i),
        .dbl_i   (dbl_i),
        .src_a_i (src_a),
        .src_k_i (src_k),
        .vld_o   (vld_o),
        .res_o   (res_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    // exact integer model of one element: value = m * 2^(t - bias - mw)
    function automatic logic [63:0] ref_scale(input logic [63:0] x, input longint kk,
                                              input longint ew, input longint mw,
                                              output bit ov, output bit un);
        longint unsigned one, sbit, e, f, m, sg;
        longint emax, t, k;
        bit g, st;
        ov   = 1'b0;
        un   = 1'b0;
        one  = 64'd1 << mw;
        sbit = 64'd1 << (ew + mw);
        emax = (64'sd1 << ew) - 64'sd1;
        sg   = ((x & sbit) != 64'd0) ? sbit : 64'd0;
        e    = (x >> mw) & longint'(emax);
        f    = x & (one - 64'd1);
        if (e == longint'(emax)) return (f != 64'd0) ? (x | (one >> 1)) : x;
        if (e == 64'd0 && f == 64'd0) return x;
        m = (e == 64'd0) ? f : (f | one);
        t = (e == 64'd0) ? 64'sd1 : longint'(e);
        k = kk;
        if (k > 64'sd100000)  k = 64'sd100000;
        if (k < -64'sd100000) k = -64'sd100000;
        t = t + k;
        while (m < one) begin
            m = m << 1;
            t = t - 64'sd1;
        end
        if (t >= emax) begin
            ov = 1'b1;
            return sg | (longint'(emax) << mw);
        end
        if (t >= 64'sd1) return sg | (longint'(t) << mw) | (m & (one - 64'd1));
        g  = 1'b0;
        st = 1'b0;
        if (t < -(mw + 64'sd8)) begin
            m  = 64'd0;
            st = 1'b1;
            t  = 64'sd1;
        end
        while (t < 64'sd1) begin
            st = st | g;
            g  = m[0];
            m  = m >> 1;
            t  = t + 64'sd1;
        end
        if (g && (st || m[0])) m = m + 64'd1;
        un = (m == 64'd0);
        return sg | m;
    endfunction

    task automatic model(input bit d, input logic [127:0] a, input logic [127:0] k,
                         output logic [127:0] r, output logic [3:0] ov, output logic [3:0] un);
        r  = '0;
        ov = '0;
        un = '0;
        if (d) begin
            for (int j = 0; j < 2; j++) begin
                bit o, u;
                r[64*j +: 64] = ref_scale(a[64*j +: 64], longint'($signed(k[64*j +: 64])),
                                          64'sd11, 64'sd52, o, u);
                ov[j] = o;
                un[j] = u;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit o, u;
                logic [63:0] w;
                w = ref_scale({32'd0, a[32*i +: 32]}, longint'($signed(k[32*i +: 32])),
                              64'sd8, 64'sd23, o, u);
                r[32*i +: 32] = w[31:0];
                ov[i] = o;
                un[i] = u;
            end
        end
    endtask

    task automatic check();
        n_cmp++;
        if (vld_o !== e_vld || res_o !== e_res || ovf_o !== e_ovf || unf_o !== e_unf) begin
            n_bad++;
            $display("FAIL %s: got vld=%b res=%h ovf=%b unf=%b expected vld=%b res=%h ovf=%b unf=%b",
                     e_tag, vld_o, res_o, ovf_o, unf_o, e_vld, e_res, e_ovf, e_unf);
        end
    endtask

    // compare the previous cycle's outcome, then present the next operands
    task automatic step(input bit v, input bit d, input logic [127:0] av,
                        input logic [127:0] kv, input string tag);
        @(negedge clk);
        check();
        vld_i = v;
        dbl_i = d;
        src_a = av;
        src_k = kv;
        e_tag = tag;
        if (v) begin
            model(d, av, kv, e_res, e_ovf, e_unf);
            e_vld = 1'b1;
        end else begin
            e_vld = 1'b0;
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [31:0] small32();
        return 32'($signed(int'($urandom_range(700)) - 350));
    endfunction

    initial begin
        rst_n = 1'b0;
        vld_i = 1'b0;
        dbl_i = 1'b0;
        src_a = '0;
        src_k = '0;
        e_vld = 1'b0;
        e_res = '0;
        e_ovf = '0;
        e_unf = '0;
        e_tag = "R12 reset state";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: worked binary32 examples
        step(1, 0, {32'h3f800000, 32'h3f900000, 32'h3fc00000, 32'h3fe00000},
                   {32'hffffffff, 32'd2, 32'd3, 32'd4}, "R1");
        // R2: binary64 elements with 64-bit scales
        step(1, 1, {64'h3ff0000000000000, 64'h3ff2000000000000},
                   {64'hffffffffffffffff, 64'd2}, "R2");
        // R3: overflow to signed infinity, both widths
        step(1, 0, {32'h7f000000, 32'hff000000, 32'h3f800000, 32'h3f800000},
                   {32'd1, 32'd1, 32'd128, 32'd127}, "R3");
        step(1, 1, {64'h7fe0000000000000, 64'hbff0000000000000},
                   {64'd1, 64'd1024}, "R3");
        // R4: rounding into the subnormal range
        step(1, 0, {32'h3f800000, 32'h3fc00000, 32'h3fa00000, 32'h3fe00000},
                   {32'hffffff81, 32'hffffff6b, 32'hffffff6b, 32'hffffff6c}, "R4");
        step(1, 0, {32'h3fffffff, 32'hbf7fffff, 32'h3f800000, 32'h3f400000},
                   {32'hffffff82, 32'hffffff82, 32'hffffff82, 32'hffffff82}, "R4");
        // R5: flush to signed zero, including the tie at half the smallest subnormal
        step(1, 0, {32'h3f800000, 32'hbf800000, 32'h3f800001, 32'h3fc00000},
                   {32'hffffff6a, 32'hffffff69, 32'hffffff6a, 32'hffffff6a}, "R5");
        step(1, 1, {64'h3ff0000000000000, 64'hbff8000000000000},
                   {64'hfffffffffffffbcd, 64'hfffffffffffffbcd}, "R5");
        // R6: zero, infinity and quiet NaN pass through
        step(1, 0, {32'h00000000, 32'h80000000, 32'h7f800000, 32'h7fc00123},
                   {32'd5, 32'hfffffffd, 32'hffffff38, 32'd7}, "R6");
        step(1, 1, {64'hfff0000000000000, 64'h8000000000000000},
                   {64'd3000, 64'h8000000000000000}, "R6");
        // R7: signalling NaN is quietened
        step(1, 0, {32'h7f800001, 32'hff812345, 32'h7fc00000, 32'hffc00001},
                   {32'd0, 32'd3, 32'd1, 32'hffffffff}, "R7");
        step(1, 1, {64'h7ff0000000000001, 64'hfff4000000000000},
                   {64'd9, 64'd0}, "R7");
        // R8: subnormal inputs keep full precision
        step(1, 0, {32'h00000001, 32'h00400000, 32'h80000003, 32'h00000001},
                   {32'd149, 32'd1, 32'd10, 32'd0}, "R8");
        step(1, 1, {64'h0000000000000001, 64'h800fffffffffffff},
                   {64'd1074, 64'd2}, "R8");
        // R9: extreme scale integers saturate without wrapping
        step(1, 0, {32'h3f800000, 32'h3f800000, 32'h7f7fffff, 32'h00000001},
                   {32'h7fffffff, 32'h80000000, 32'h80000000, 32'h7fffffff}, "R9");
        step(1, 1, {64'h3ff0000000000000, 64'h0000000000000001},
                   {64'h0000000100000000, 64'h8000000000000000}, "R9");
        step(1, 1, {64'h7fefffffffffffff, 64'h3ff0000000000000},
                   {64'hffffffff00000000, 64'h7fffffffffffffff}, "R9");
        // R13: double-mode overflow in both elements leaves upper flag bits clear
        step(1, 1, {64'h7fe0000000000000, 64'h7fe0000000000000},
                   {64'd5, 64'd5}, "R13");
        // R10 / R11: idle cycles with changing operands must not disturb outputs
        step(0, 0, rnd128(), rnd128(), "R11");
        step(0, 1, rnd128(), rnd128(), "R11");
        step(1, 0, {32'h40000000, 32'h40000000, 32'h40000000, 32'h40000000},
                   {32'd1, 32'd2, 32'd3, 32'd4}, "R10");
        step(0, 1, rnd128(), rnd128(), "R10");

        // mixed traffic with random operands and small scales
        for (int n = 0; n < 400; n++) begin
            logic [127:0] a, k;
            bit v, d;
            v = ($urandom_range(3) != 0);
            d = $urandom_range(1) != 0;
            a = rnd128();
            if ($urandom_range(7) == 0) begin
                k = rnd128();
            end else if (d) begin
                k = {{32{small32()}}, small32()};
                k = {{32{k[127]}}, k[127:96], {32{k[31]}}, k[31:0]};
            end else begin
                k = {small32(), small32(), small32(), small32()};
            end
            if (!v)     step(v, d, a, k, "R11");
            else if (d) step(v, d, a, k, "R2");
            else        step(v, d, a, k, "R1");
        end

        @(negedge clk);
        check();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: run finished=%0d expected=1", done);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule